// File: doc/BRIEF.md
# Isochronous Sync-Code Sequencer

This block manages the 4-bit synchronization-code field of isochronous packets. On the transmit side it follows a stream from its start command to its stop command. For each packet header being built, it presents the code that belongs to the packet's position in the stream. The first packet gets the start code, the packets after it get the normal code, and the closing packet gets the stop code. Three host-written code inputs supply these values.

On the receive side the block watches the sync field of every arriving packet. It opens a reception window on a packet whose field equals the start code and closes the window on a packet whose field equals the stop code. It raises an accept flag for each packet that falls inside the window, and both the opening packet and the closing packet are accepted.

When the sync-enable input is low, position-dependent coding is switched off. Transmit then uses the normal code for every packet, and receive accepts every packet.

Top module: `iso_sync_seq`

## Requirements
- R1: After reset, tx_active, tx_last, rx_active and rx_accept are all low.
- R2: With sync_en high, tx_code equals code_start during the first tx_hdr cycle after a tx_start pulse. tx_code is combinational and is valid in the same cycle as tx_hdr.
- R3: With sync_en high, every later tx_hdr of the same stream, before tx_stop, presents code_norm.
- R4: After tx_stop, the next tx_hdr presents code_stop (with sync_en high) and has tx_last high. tx_active falls in the cycle after that header.
- R5: A tx_stop that arrives before any tx_hdr of the stream returns tx_active low without a packet. The following tx_start again uses code_start.
- R6: With sync_en low, every transmitted header presents code_norm, the first and last included.
- R7: A tx_start pulse while tx_active is high has no effect on the codes of the running stream.
- R8: rx_accept is a registered flag, high in the cycle after an rx_valid pulse whose packet is accepted. While the window is closed and sync_en is high, a packet matching code_start is accepted and sets rx_active. A packet matching no code is dropped.
- R9: While rx_active is high, every valid packet is accepted. A packet matching code_start does not reset or close the window.
- R10: While rx_active is high, a packet matching code_stop is accepted and rx_active falls with it. This also holds for a stop packet that directly follows the start packet.
- R11: With sync_en low, every valid packet is accepted and rx_active stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | Enables position-dependent coding and receive gating |
| code_start | input | 4 | Code for the first packet and for opening the window |
| code_norm | input | 4 | Code for packets in the middle of a stream |
| code_stop | input | 4 | Code for the last packet and for closing the window |
| tx_start | input | 1 | One-cycle transmit start command |
| tx_stop | input | 1 | One-cycle transmit stop command |
| tx_hdr | input | 1 | Header-build strobe, one cycle per outgoing packet |
| tx_code | output | 4 | Sync code for the header being built |
| tx_last | output | 1 | The header being built closes the stream |
| tx_active | output | 1 | A transmit stream is open |
| rx_valid | input | 1 | Received packet strobe |
| rx_code | input | 4 | Sync field of the received packet |
| rx_accept | output | 1 | Previous received packet was accepted |
| rx_active | output | 1 | Reception window is open |

## Verification
The assertions assume that tx_start, tx_stop and tx_hdr are single-cycle pulses. They also assume that sync_en and the three code inputs stay constant around a packet. The receive properties further assume that code_start and code_stop differ. The bench keeps to these assumptions: it writes the codes once with three distinct values, changes sync_en only while both sides are idle, and never drives a command in the same cycle as a header strobe.

// File: rtl/iso_sync_pkg.sv
package iso_sync_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_FIRST = 2'd1,
        TX_RUN   = 2'd2,
        TX_LAST  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/iso_tx_seq.sv
module iso_tx_seq
    import iso_sync_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_en,
    input  logic [CODE_W-1:0] code_start,
    input  logic [CODE_W-1:0] code_norm,
    input  logic [CODE_W-1:0] code_stop,
    input  logic              tx_start,
    input  logic              tx_stop,
    input  logic              tx_hdr,
    output logic [CODE_W-1:0] tx_code,
    output logic              tx_last,
    output logic              tx_active
);
    typedef struct packed {
        tx_state_e st;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            TX_IDLE: begin
                if (tx_start) r_d.st = TX_FIRST;
            end
            TX_FIRST: begin
                // a stop before any header closes the stream with no packet
                if (tx_hdr && tx_stop) r_d.st = TX_LAST;
                else if (tx_hdr)       r_d.st = TX_RUN;
                else if (tx_stop)      r_d.st = TX_IDLE;
            end
            TX_RUN: begin
                if (tx_stop) r_d.st = TX_LAST;
            end
            TX_LAST: begin
                if (tx_hdr) r_d.st = TX_IDLE;
            end
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_code = code_norm;
        if (sync_en && r_q.st == TX_FIRST) tx_code = code_start;
        if (sync_en && r_q.st == TX_LAST)  tx_code = code_stop;
    end

    assign tx_last   = (r_q.st == TX_LAST);
    assign tx_active = (r_q.st != TX_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.st <= TX_IDLE;
        else        r_q    <= r_d;
    end
endmodule

// File: rtl/iso_rx_gate.sv
module iso_rx_gate #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_en,
    input  logic [CODE_W-1:0] code_start,
    input  logic [CODE_W-1:0] code_stop,
    input  logic              rx_valid,
    input  logic [CODE_W-1:0] rx_code,
    output logic              rx_accept,
    output logic              rx_active
);
    typedef struct packed {
        logic open;
        logic acc;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic hit_start, hit_stop;

    assign hit_start = (rx_code == code_start);
    assign hit_stop  = (rx_code == code_stop);

    always_comb begin
        r_d     = r_q;
        r_d.acc = 1'b0;
        if (!sync_en) begin
            r_d.open = 1'b0;
            r_d.acc  = rx_valid;
        end else if (rx_valid) begin
            if (r_q.open) begin
                r_d.acc = 1'b1;
                if (hit_stop) r_d.open = 1'b0;
            end else if (hit_start) begin
                r_d.acc  = 1'b1;
                r_d.open = !hit_stop;
            end
        end
    end

    assign rx_accept = r_q.acc;
    assign rx_active = r_q.open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/iso_sync_seq.sv
module iso_sync_seq #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_en,
    input  logic [CODE_W-1:0] code_start,
    input  logic [CODE_W-1:0] code_norm,
    input  logic [CODE_W-1:0] code_stop,
    input  logic              tx_start,
    input  logic              tx_stop,
    input  logic              tx_hdr,
    output logic [CODE_W-1:0] tx_code,
    output logic              tx_last,
    output logic              tx_active,
    input  logic              rx_valid,
    input  logic [CODE_W-1:0] rx_code,
    output logic              rx_accept,
    output logic              rx_active
);
    iso_tx_seq #(.CODE_W(CODE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en),
        .code_start(code_start), .code_norm(code_norm), .code_stop(code_stop),
        .tx_start(tx_start), .tx_stop(tx_stop), .tx_hdr(tx_hdr),
        .tx_code(tx_code), .tx_last(tx_last), .tx_active(tx_active)
    );

    iso_rx_gate #(.CODE_W(CODE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en),
        .code_start(code_start), .code_stop(code_stop),
        .rx_valid(rx_valid), .rx_code(rx_code),
        .rx_accept(rx_accept), .rx_active(rx_active)
    );
endmodule

// File: rtl/iso_sync_chk.sv
module iso_sync_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_en,
    input logic [CODE_W-1:0] code_start,
    input logic [CODE_W-1:0] code_stop,
    input logic              tx_start,
    input logic              tx_hdr,
    input logic              tx_last,
    input logic              tx_active,
    input logic              rx_valid,
    input logic [CODE_W-1:0] rx_code,
    input logic              rx_accept,
    input logic              rx_active
);
    // R2
    tx_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && tx_start) |=> tx_active);
    // R4
    tx_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hdr && tx_last) |=> !tx_active);
    // R4
    tx_last_in_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_active);
    // R8
    rx_accept_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept |-> $past(rx_valid));
    // R8
    rx_drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && !rx_active && rx_valid && rx_code != code_start) |=> !rx_accept);
    // R9
    rx_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && rx_active && rx_valid) |=> rx_accept);
    // R10
    rx_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && rx_active && rx_valid && rx_code == code_stop
         && code_start != code_stop) |=> !rx_active);
    // R11
    rx_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en && rx_valid) |=> (rx_accept && !rx_active));
endmodule

bind iso_sync_seq iso_sync_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en),
    .code_start(code_start), .code_stop(code_stop),
    .tx_start(tx_start), .tx_hdr(tx_hdr), .tx_last(tx_last), .tx_active(tx_active),
    .rx_valid(rx_valid), .rx_code(rx_code),
    .rx_accept(rx_accept), .rx_active(rx_active)
);

// File: tb/iso_sync_seq_bench.sv
`timescale 1ns/1ps
module iso_sync_seq_bench;
    localparam logic [3:0] CS = 4'hA, CN = 4'h3, CP = 4'h5, CX = 4'h7;

    logic clk = 1'b0, rst_n = 1'b0, sync_en = 1'b1;
    logic [3:0] code_start = CS, code_norm = CN, code_stop = CP;
    logic tx_start = 0, tx_stop = 0, tx_hdr = 0, rx_valid = 0;
    logic [3:0] rx_code = '0;
    logic [3:0] tx_code;
    logic tx_last, tx_active, rx_accept, rx_active;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    iso_sync_seq u_iso_sync_seq (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en),
        .code_start(code_start), .code_norm(code_norm), .code_stop(code_stop),
        .tx_start(tx_start), .tx_stop(tx_stop), .tx_hdr(tx_hdr),
        .tx_code(tx_code), .tx_last(tx_last), .tx_active(tx_active),
        .rx_valid(rx_valid), .rx_code(rx_code),
        .rx_accept(rx_accept), .rx_active(rx_active)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) tx_start = 1;
        @(negedge clk) tx_start = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) tx_stop = 1;
        @(negedge clk) tx_stop = 0;
    endtask

    task automatic send_hdr(string req, logic [3:0] exp_code, logic exp_last);
        @(negedge clk) tx_hdr = 1;
        #1;
        chk({req, " code"}, tx_code, exp_code);
        chk({req, " last"}, tx_last, exp_last);
        @(negedge clk) tx_hdr = 0;
    endtask

    task automatic recv(string req, logic [3:0] c, logic exp_acc, logic exp_act);
        @(negedge clk) begin rx_valid = 1; rx_code = c; end
        @(negedge clk) rx_valid = 0;
        #1;
        chk({req, " accept"}, rx_accept, exp_acc);
        chk({req, " active"}, rx_active, exp_act);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 tx_active", tx_active, 0);
        chk("R1 tx_last", tx_last, 0);
        chk("R1 rx_active", rx_active, 0);
        chk("R1 rx_accept", rx_accept, 0);
    endtask

    task automatic t_tx_stream();
        pulse_start();
        chk("R2 active", tx_active, 1);
        send_hdr("R2 first", CS, 0);
        send_hdr("R3 middle", CN, 0);
        pulse_start();                       // R7 ignored while running
        send_hdr("R7 middle after start", CN, 0);
        send_hdr("R3 middle2", CN, 0);
        pulse_stop();
        send_hdr("R4 final", CP, 1);
        #1 chk("R4 closed", tx_active, 0);
    endtask

    task automatic t_tx_early_stop();
        pulse_start();
        pulse_stop();
        #1 chk("R5 idle", tx_active, 0);
        pulse_start();
        send_hdr("R5 restart first", CS, 0);
        pulse_stop();
        send_hdr("R5 final", CP, 1);
    endtask

    task automatic t_tx_no_sync();
        sync_en = 0;
        pulse_start();
        send_hdr("R6 first", CN, 0);
        send_hdr("R6 middle", CN, 0);
        pulse_stop();
        send_hdr("R6 final", CN, 1);
        sync_en = 1;
    endtask

    task automatic t_rx_window();
        recv("R8 drop idle", CX, 0, 0);
        recv("R8 drop norm idle", CN, 0, 0);
        recv("R8 open", CS, 1, 1);
        recv("R9 inside", CX, 1, 1);
        recv("R9 repeat start", CS, 1, 1);
        recv("R10 close", CP, 1, 0);
        recv("R8 drop after close", CX, 0, 0);
        recv("R8 stop while idle", CP, 0, 0);
    endtask

    task automatic t_rx_back_to_back();
        @(negedge clk) begin rx_valid = 1; rx_code = CS; end
        @(negedge clk) begin rx_code = CP; #1;
            chk("R10 b2b start accept", rx_accept, 1);
            chk("R10 b2b start active", rx_active, 1); end
        @(negedge clk) rx_valid = 0;
        #1;
        chk("R10 b2b stop accept", rx_accept, 1);
        chk("R10 b2b stop active", rx_active, 0);
        @(negedge clk) #1 chk("R8 accept single cycle", rx_accept, 0);
    endtask

    task automatic t_rx_no_sync();
        sync_en = 0;
        recv("R11 any", CX, 1, 0);
        recv("R11 start code", CS, 1, 0);
        sync_en = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_tx_stream();
        t_tx_early_stop();
        t_tx_no_sync();
        t_rx_window();
        t_rx_back_to_back();
        t_rx_no_sync();
        repeat (2) @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule